// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Router

The router accepts one interrupt command at a time. It resolves which registered processor interrupt controllers should receive the command and issues one delivery strobe for each of them. A command carries a vector, a 3-bit delivery mode, a destination mode bit, a 2-bit destination shorthand, an 8-bit destination field, the 8-bit sender ID, a 4-bit destination format model and an 8-bit external IRQ number. Each command ends with a single-cycle `done` or `err` pulse.

A small target table holds a presence bit and an 8-bit logical ID for each of `N_TGT` targets. A write port fills the table. Physical addressing picks one target by index. Logical addressing matches each target's logical ID against the destination field, using either a flat model or a cluster model. The self, all and all-but-sender shorthands work with physical addressing. A fixed set of illegal combinations is rejected before any delivery is made.

After it accepts a command, the block scans the table one target per clock, starting at index 0. Lowest-priority arbitration and any start-up state handling in the targets are left to the receivers.

Top module: `ipi_router`

## Requirements
- R1: `cmd_ready` is high only while the block is idle, and a command is accepted on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` stays low from the cycle after acceptance through the cycle of the closing `done`/`err` pulse, and is high again in the cycle that follows.
- R2: A table write (`tbl_we`) sets the presence bit and logical ID of entry `tbl_idx`, and it takes effect from the next cycle. Reset clears every presence bit. A command accepted in the same cycle as a write is checked against the table contents from before that write.
- R3: For an accepted, legal command, target k is examined in the (k+1)-th cycle after acceptance, and any strobe in that cycle carries `dlv_tgt` = k. `done` is high in cycle `N_TGT`+1 after acceptance.
- R4: Shorthand 0 with destination mode 0 (physical) delivers only to the target whose index equals `cmd_dest`.
- R5: Shorthand 0 with destination mode 1 (logical) and model 4'hF (flat) delivers to each present target whose logical ID ANDed with `cmd_dest` is nonzero. A `cmd_dest` of 8'hFF reaches every present target.
- R6: Shorthand 0 with destination mode 1 and model 4'h0 (cluster) delivers to each present target whose logical ID has an upper nibble equal to `cmd_dest[7:4]` and a lower nibble whose AND with `cmd_dest[3:0]` is nonzero. A `cmd_dest` of 8'hFF reaches every present target.
- R7: With physical destination mode, shorthand 1 delivers to the sender's own index if that target is present. Shorthand 2 delivers to every present target. Shorthand 3 delivers to every present target except the sender.
- R8: Delivery modes 0, 1 and 7 produce strobes. The strobe vector is `cmd_extirq` for mode 7 and `cmd_vec` for modes 0 and 1. Modes 2, 4, 5 and 6 produce no strobes and still end with `done`.
- R9: `err` is pulsed in the first cycle after acceptance, with no strobes, in any of these cases:
  - the sender ID is not below `N_TGT`;
  - the sender is absent and differs from `IOC_ID`;
  - the delivery mode is 3;
  - shorthand 0 in physical mode names an index that is out of range or absent;
  - shorthand 0 in logical mode uses a model other than 4'h0 or 4'hF;
  - shorthand 1, 2 or 3 is used with logical mode;
  - shorthand 1 in physical mode has `cmd_dest` equal to `IOC_ID`.
- R10: `done` and `err` are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write enable |
| tbl_idx | input | IW | Table entry to write |
| tbl_present | input | 1 | Presence bit to store |
| tbl_lid | input | 8 | Logical ID to store |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_vec | input | 8 | Interrupt vector |
| cmd_dlv | input | 3 | Delivery mode |
| cmd_dmode | input | 1 | Destination mode, 0 physical, 1 logical |
| cmd_sh | input | 2 | Destination shorthand |
| cmd_dest | input | 8 | Destination index or message address |
| cmd_src | input | 8 | Sender ID |
| cmd_model | input | 4 | Destination format model |
| cmd_extirq | input | 8 | External IRQ number for mode 7 |
| dlv_valid | output | 1 | Delivery strobe |
| dlv_tgt | output | IW | Target index of the strobe |
| dlv_vec | output | 8 | Vector carried by the strobe |
| done | output | 1 | Command completed |
| err | output | 1 | Command rejected |

## Verification
A table write and the acceptance of a command can land on the same clock edge. The rule is that the legality check uses the table as it stood before that write. The bench provokes this by first clearing one entry, then offering a physical command aimed at that entry in the very cycle that re-registers it. The command must end in `err` with no strobes, and a repeat of the same command afterwards must deliver normally.

// File: rtl/ipi_router_pkg.sv
`timescale 1ns/1ps
package ipi_router_pkg;

    localparam logic [1:0] SH_DEST   = 2'd0;
    localparam logic [1:0] SH_SELF   = 2'd1;
    localparam logic [1:0] SH_ALL    = 2'd2;
    localparam logic [1:0] SH_OTHERS = 2'd3;

    localparam logic [2:0] DM_RSVD = 3'd3;
    localparam logic [2:0] DM_EXT  = 3'd7;

    localparam logic [3:0] MODEL_FLAT    = 4'hF;
    localparam logic [3:0] MODEL_CLUSTER = 4'h0;

    typedef struct packed {
        logic [7:0] vec;
        logic [2:0] dlv;
        logic       dmode;
        logic [1:0] sh;
        logic [7:0] dest;
        logic [7:0] src;
        logic [3:0] model;
        logic [7:0] extirq;
    } ipi_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_FIN  = 2'd2
    } ipi_state_e;

    function automatic logic raises_irq(input logic [2:0] mode);
        return (mode == 3'd0) || (mode == 3'd1) || (mode == DM_EXT);
    endfunction

endpackage

// File: rtl/ipi_target_table.sv
`timescale 1ns/1ps
module ipi_target_table #(
    parameter int N_TGT = 8,
    parameter int IW    = $clog2(N_TGT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic                  wr_present,
    input  logic [7:0]            wr_lid,
    output logic [N_TGT-1:0]      present_o,
    output logic [N_TGT-1:0][7:0] lid_o
);

    for (genvar g = 0; g < N_TGT; g++) begin : g_entry
        logic       pres_d, pres_q;
        logic [7:0] lid_d,  lid_q;

        always_comb begin
            pres_d = pres_q;
            lid_d  = lid_q;
            if (wr_en && (wr_idx == IW'(g))) begin
                pres_d = wr_present;
                lid_d  = wr_lid;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pres_q <= 1'b0;
                lid_q  <= 8'h00;
            end else begin
                pres_q <= pres_d;
                lid_q  <= lid_d;
            end
        end

        assign present_o[g] = pres_q;
        assign lid_o[g]     = lid_q;
    end

endmodule

// File: rtl/ipi_cmd_check.sv
`timescale 1ns/1ps
module ipi_cmd_check
    import ipi_router_pkg::*;
#(
    parameter int N_TGT  = 8,
    parameter int IW     = $clog2(N_TGT),
    parameter int IOC_ID = 7
) (
    input  logic [N_TGT-1:0] present,
    input  logic [7:0]       src,
    input  logic [7:0]       dest,
    input  logic [2:0]       dlv,
    input  logic             dmode,
    input  logic [1:0]       sh,
    input  logic [3:0]       model,
    output logic             bad
);

    logic src_in, src_pres, dst_in, dst_pres, bad_src, bad_route;

    always_comb begin
        src_in   = ({1'b0, src}  < 9'(N_TGT));
        dst_in   = ({1'b0, dest} < 9'(N_TGT));
        src_pres = src_in && present[src[IW-1:0]];
        dst_pres = dst_in && present[dest[IW-1:0]];
        bad_src  = !src_in || (!src_pres && (src != 8'(IOC_ID)));

        unique case (sh)
            SH_DEST:  bad_route = dmode ? ((model != MODEL_FLAT) && (model != MODEL_CLUSTER))
                                        : !dst_pres;
            SH_SELF:  bad_route = dmode || (dest == 8'(IOC_ID));
            default:  bad_route = dmode;
        endcase

        bad = bad_src || (dlv == DM_RSVD) || bad_route;
    end

endmodule

// File: rtl/ipi_tgt_match.sv
`timescale 1ns/1ps
module ipi_tgt_match
    import ipi_router_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic [IW-1:0] idx,
    input  logic          pres,
    input  logic [7:0]    lid,
    input  logic [7:0]    dest,
    input  logic [7:0]    src,
    input  logic          dmode,
    input  logic [1:0]    sh,
    input  logic [3:0]    model,
    output logic          hit
);

    logic [7:0] idx8;
    logic       bcast, flat_hit, clu_hit, sel;

    always_comb begin
        idx8     = 8'(idx);
        bcast    = (dest == 8'hFF);
        flat_hit = bcast || ((lid & dest) != 8'h00);
        clu_hit  = bcast || ((dest[7:4] == lid[7:4]) && ((dest[3:0] & lid[3:0]) != 4'h0));

        unique case (sh)
            SH_DEST: begin
                if (!dmode)                      sel = (idx8 == dest);
                else if (model == MODEL_FLAT)    sel = flat_hit;
                else if (model == MODEL_CLUSTER) sel = clu_hit;
                else                             sel = 1'b0;
            end
            SH_SELF:   sel = (idx8 == src);
            SH_ALL:    sel = 1'b1;
            default:   sel = (idx8 != src);
        endcase

        hit = pres && sel;
    end

endmodule

// File: rtl/ipi_router.sv
`timescale 1ns/1ps
module ipi_router
    import ipi_router_pkg::*;
#(
    parameter int N_TGT  = 8,
    parameter int IOC_ID = 7,
    localparam int IW    = $clog2(N_TGT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tbl_we,
    input  logic [IW-1:0] tbl_idx,
    input  logic          tbl_present,
    input  logic [7:0]    tbl_lid,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [7:0]    cmd_vec,
    input  logic [2:0]    cmd_dlv,
    input  logic          cmd_dmode,
    input  logic [1:0]    cmd_sh,
    input  logic [7:0]    cmd_dest,
    input  logic [7:0]    cmd_src,
    input  logic [3:0]    cmd_model,
    input  logic [7:0]    cmd_extirq,
    output logic          dlv_valid,
    output logic [IW-1:0] dlv_tgt,
    output logic [7:0]    dlv_vec,
    output logic          done,
    output logic          err
);

    localparam logic [IW-1:0] LAST = IW'(N_TGT - 1);

    typedef struct packed {
        ipi_state_e    st;
        logic [IW-1:0] idx;
        logic          bad;
        ipi_cmd_t      cmd;
    } rtr_state_t;

    localparam rtr_state_t RST_VAL = '{st: ST_IDLE, idx: '0, bad: 1'b0, cmd: '0};

    rtr_state_t s_d, s_q;

    logic [N_TGT-1:0]      present;
    logic [N_TGT-1:0][7:0] lid;
    logic                  in_bad;
    logic                  hit;
    ipi_cmd_t              in_cmd;

    ipi_target_table #(.N_TGT(N_TGT), .IW(IW)) table_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tbl_we),
        .wr_idx     (tbl_idx),
        .wr_present (tbl_present),
        .wr_lid     (tbl_lid),
        .present_o  (present),
        .lid_o      (lid)
    );

    ipi_cmd_check #(.N_TGT(N_TGT), .IW(IW), .IOC_ID(IOC_ID)) check_i (
        .present (present),
        .src     (cmd_src),
        .dest    (cmd_dest),
        .dlv     (cmd_dlv),
        .dmode   (cmd_dmode),
        .sh      (cmd_sh),
        .model   (cmd_model),
        .bad     (in_bad)
    );

    ipi_tgt_match #(.IW(IW)) match_i (
        .idx   (s_q.idx),
        .pres  (present[s_q.idx]),
        .lid   (lid[s_q.idx]),
        .dest  (s_q.cmd.dest),
        .src   (s_q.cmd.src),
        .dmode (s_q.cmd.dmode),
        .sh    (s_q.cmd.sh),
        .model (s_q.cmd.model),
        .hit   (hit)
    );

    always_comb begin
        in_cmd = '{vec: cmd_vec, dlv: cmd_dlv, dmode: cmd_dmode, sh: cmd_sh,
                   dest: cmd_dest, src: cmd_src, model: cmd_model, extirq: cmd_extirq};
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    s_d.cmd = in_cmd;
                    s_d.idx = '0;
                    s_d.bad = in_bad;
                    s_d.st  = in_bad ? ST_FIN : ST_SCAN;
                end
            end
            ST_SCAN: begin
                s_d.idx = s_q.idx + IW'(1);
                if (s_q.idx == LAST) s_d.st = ST_FIN;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= RST_VAL;
        else        s_q <= s_d;
    end

    assign cmd_ready = (s_q.st == ST_IDLE);
    assign dlv_valid = (s_q.st == ST_SCAN) && hit && raises_irq(s_q.cmd.dlv);
    assign dlv_tgt   = s_q.idx;
    assign dlv_vec   = (s_q.cmd.dlv == DM_EXT) ? s_q.cmd.extirq : s_q.cmd.vec;
    assign done      = (s_q.st == ST_FIN) && !s_q.bad;
    assign err       = (s_q.st == ST_FIN) &&  s_q.bad;

endmodule

// File: rtl/ipi_router_chk.sv
`timescale 1ns/1ps
module ipi_router_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic dlv_valid,
    input logic done,
    input logic err
);

    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    a_r1_ready_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> cmd_ready);

    a_r3_strobe_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> !cmd_ready);

    a_r9_err_right_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(cmd_valid && cmd_ready));

    a_r9_no_strobe_with_err: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !dlv_valid);

    a_r10_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

endmodule

bind ipi_router ipi_router_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .dlv_valid (dlv_valid),
    .done      (done),
    .err       (err)
);

// File: tb/ipi_router_tb_top.sv
`timescale 1ns/1ps
module ipi_router_tb_top;

    localparam int N   = 8;
    localparam int IOC = 7;
    localparam int IW  = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tbl_we = 1'b0;
    logic [IW-1:0] tbl_idx = '0;
    logic          tbl_present = 1'b0;
    logic [7:0]    tbl_lid = 8'h00;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [7:0]    cmd_vec = 8'h00;
    logic [2:0]    cmd_dlv = 3'd0;
    logic          cmd_dmode = 1'b0;
    logic [1:0]    cmd_sh = 2'd0;
    logic [7:0]    cmd_dest = 8'h00;
    logic [7:0]    cmd_src = 8'h00;
    logic [3:0]    cmd_model = 4'h0;
    logic [7:0]    cmd_extirq = 8'h00;
    logic          dlv_valid;
    logic [IW-1:0] dlv_tgt;
    logic [7:0]    dlv_vec;
    logic          done;
    logic          err;

    always #2.5 clk = ~clk;

    ipi_router #(.N_TGT(N), .IOC_ID(IOC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_present(tbl_present), .tbl_lid(tbl_lid),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_vec(cmd_vec), .cmd_dlv(cmd_dlv), .cmd_dmode(cmd_dmode), .cmd_sh(cmd_sh),
        .cmd_dest(cmd_dest), .cmd_src(cmd_src), .cmd_model(cmd_model), .cmd_extirq(cmd_extirq),
        .dlv_valid(dlv_valid), .dlv_tgt(dlv_tgt), .dlv_vec(dlv_vec),
        .done(done), .err(err)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit         m_pres [N];
    bit [7:0]   m_lid  [N];
    bit         got_err;
    bit [N-1:0] got_mask;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic void ref_model(input bit [2:0] dlv, input bit dm, input bit [1:0] sh,
                                      input bit [7:0] dest, input bit [7:0] src,
                                      input bit [3:0] model,
                                      output bit e, output bit [N-1:0] m);
        e = 1'b0;
        m = '0;
        if (src >= N) e = 1'b1;
        else if (!m_pres[src] && src != IOC) e = 1'b1;
        if (dlv == 3'd3) e = 1'b1;
        case (sh)
            2'd0: if (dm) begin
                      if (model != 4'h0 && model != 4'hF) e = 1'b1;
                  end else begin
                      if (dest >= N) e = 1'b1;
                      else if (!m_pres[dest]) e = 1'b1;
                  end
            2'd1: if (dm || dest == IOC) e = 1'b1;
            default: if (dm) e = 1'b1;
        endcase
        if (e) return;
        if (!(dlv == 3'd0 || dlv == 3'd1 || dlv == 3'd7)) return;
        for (int i = 0; i < N; i++) begin
            bit s;
            s = 1'b0;
            if (m_pres[i]) begin
                case (sh)
                    2'd0: if (!dm) s = (i == dest);
                          else if (model == 4'hF) s = (dest == 8'hFF) || ((m_lid[i] & dest) != 0);
                          else s = (dest == 8'hFF) ||
                                   ((m_lid[i][7:4] == dest[7:4]) && ((m_lid[i][3:0] & dest[3:0]) != 0));
                    2'd1: s = (i == src);
                    2'd2: s = 1'b1;
                    default: s = (i != src);
                endcase
            end
            m[i] = s;
        end
    endfunction

    function automatic string tag_for(input bit [2:0] dlv, input bit dm, input bit [1:0] sh,
                                      input bit [3:0] model);
        if (!(dlv == 3'd0 || dlv == 3'd1 || dlv == 3'd7)) return "R8";
        if (sh != 2'd0) return "R7";
        if (!dm) return "R4";
        if (model == 4'hF) return "R5";
        return "R6";
    endfunction

    task automatic reg_write(input int idx, input bit p, input bit [7:0] l);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = IW'(idx); tbl_present = p; tbl_lid = l;
        @(negedge clk);
        tbl_we = 1'b0;
        m_pres[idx] = p;
        m_lid[idx]  = l;
    endtask

    // with_reg: a table write of entry wr_idx to present with wr_lid is applied in the accept cycle
    task automatic run_cmd(input bit [7:0] vec, input bit [2:0] dlv, input bit dm,
                           input bit [1:0] sh, input bit [7:0] dest, input bit [7:0] src,
                           input bit [3:0] model, input bit [7:0] ext,
                           input bit with_reg, input int wr_idx, input bit [7:0] wr_lid);
        bit e_exp;
        bit [N-1:0] m_exp;
        bit [7:0] v_exp;
        bit vec_ok, tgt_ok, ended;
        int end_c;
        string tg;
        ref_model(dlv, dm, sh, dest, src, model, e_exp, m_exp);
        v_exp = (dlv == 3'd7) ? ext : vec;
        tg = tag_for(dlv, dm, sh, model);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_vec = vec; cmd_dlv = dlv; cmd_dmode = dm; cmd_sh = sh;
        cmd_dest = dest; cmd_src = src; cmd_model = model; cmd_extirq = ext;
        cmd_valid = 1'b1;
        if (with_reg) begin
            tbl_we = 1'b1; tbl_idx = IW'(wr_idx); tbl_present = 1'b1; tbl_lid = wr_lid;
        end
        got_mask = '0; got_err = 1'b0; vec_ok = 1'b1; tgt_ok = 1'b1; ended = 1'b0; end_c = -1;
        for (int c = 0; c < N + 3 && !ended; c++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            tbl_we = 1'b0;
            if (c == 0) chk(cmd_ready == 1'b0, "R1", "ready low after accept", cmd_ready, 0);
            if (dlv_valid) begin
                got_mask[dlv_tgt] = 1'b1;
                if (int'(dlv_tgt) != c) tgt_ok = 1'b0;
                if (dlv_vec != v_exp) vec_ok = 1'b0;
            end
            if (done || err) begin
                ended = 1'b1; end_c = c; got_err = err;
            end
        end
        if (with_reg) begin
            m_pres[wr_idx] = 1'b1;
            m_lid[wr_idx]  = wr_lid;
        end
        chk(got_err == e_exp, "R9", "error outcome", got_err, e_exp);
        if (e_exp) begin
            chk(end_c == 0 && got_mask == '0, "R9", "err at first cycle, no strobes",
                {end_c[15:0], 8'(got_mask)}, 0);
        end else begin
            chk(end_c == N, "R3", "done cycle after accept", end_c, N);
            chk(got_mask == m_exp, tg, "delivery mask", got_mask, m_exp);
            chk(tgt_ok, "R3", "strobe index equals scan cycle", tgt_ok, 1);
            chk(vec_ok, "R8", "strobe vector", vec_ok, 1);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_pres[i] = 1'b0; m_lid[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && !done && !err && !dlv_valid, "R1", "reset state",
            {cmd_ready, done, err, dlv_valid}, 4'b1000);

        // R2: empty table after reset -> physical target 0 is absent
        run_cmd(8'h40, 3'd0, 1'b0, 2'd0, 8'd0, 8'(IOC), 4'h0, 8'h00, 1'b0, 0, 8'h00);
        chk(got_err, "R2", "reset clears presence", got_err, 1);

        reg_write(0, 1'b1, 8'h11);
        reg_write(1, 1'b1, 8'h12);
        reg_write(2, 1'b1, 8'h24);
        reg_write(3, 1'b1, 8'h28);
        reg_write(4, 1'b1, 8'h31);
        reg_write(5, 1'b1, 8'h00);

        run_cmd(8'h41, 3'd0, 1'b0, 2'd0, 8'd3, 8'd0, 4'h0, 8'h00, 1'b0, 0, 8'h00);
        chk(!got_err && got_mask == 8'b0000_1000, "R2", "written entry is used", got_mask, 8'h08);

        // R2: same-cycle write and accept -> check sees old table
        reg_write(3, 1'b0, 8'h28);
        run_cmd(8'h42, 3'd0, 1'b0, 2'd0, 8'd3, 8'd0, 4'h0, 8'h00, 1'b1, 3, 8'h28);
        chk(got_err, "R2", "accept with concurrent write uses old table", got_err, 1);
        run_cmd(8'h43, 3'd0, 1'b0, 2'd0, 8'd3, 8'd0, 4'h0, 8'h00, 1'b0, 0, 8'h00);
        chk(!got_err && got_mask == 8'b0000_1000, "R2", "write visible afterwards", got_mask, 8'h08);

        // R8: delivery-mode sweep with broadcast to all
        for (int d = 0; d < 8; d++)
            run_cmd(8'hA5, 3'(d), 1'b0, 2'd2, 8'h00, 8'd0, 4'h0, 8'h3C, 1'b0, 0, 8'h00);

        // R4-R7, R9: routing sweep
        for (int sh = 0; sh < 4; sh++)
            for (int dm = 0; dm < 2; dm++)
                for (int mi = 0; mi < 3; mi++)
                    for (int k = 0; k < 48; k++)
                        for (int si = 0; si < 6; si++) begin
                            bit [3:0] mdl;
                            bit [7:0] dst, srcv;
                            mdl  = (mi == 0) ? 4'h0 : (mi == 1) ? 4'hF : 4'h5;
                            dst  = (k < 8) ? 8'(k) : (k == 47) ? 8'hFF : 8'((k * 13) & 255);
                            srcv = (si == 0) ? 8'd0 : (si == 1) ? 8'd3 : (si == 2) ? 8'd5 :
                                   (si == 3) ? 8'd6 : (si == 4) ? 8'd7 : 8'd8;
                            if (dm == 0 && mi != 0) continue;
                            run_cmd(8'(k + 16), 3'(k % 2), 1'(dm), 2'(sh), dst, srcv, mdl,
                                    8'h77, 1'b0, 0, 8'h00);
                        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule